// File: doc/BRIEF.md
# BCD Clock Calendar Counter Chain

This block keeps wall-clock time and the calendar date in seven BCD registers: seconds, minutes, hours, day of week, date of month, month and two-digit year. The chain advances once per second. The one-second tick comes from one of three sources: a prescaler that divides the block clock, a 50 Hz mains-line pulse input, or a 60 Hz mains-line pulse input. A two-bit select picks the source, and a fourth select code holds the time still.

Software sets and reads the time through a plain register port with seven consecutive addresses starting at 0x20. A write takes effect on the next clock edge. It also restarts the sub-second count, so the next advance comes one full second after the write.

The hours register holds the BCD hour together with a 12/24-hour mode bit and an AM/PM bit. Month lengths and leap years are handled inside the chain.

Top module: `rtc_bcd_chain`

## Requirements
- R1: With `src_sel` = 2'b00, the seconds register advances once every `PRESCALE_DIV` clock cycles. Between advances and writes, no register changes.
- R2: With `src_sel` = 2'b01, one advance happens per 50 rising edges of `line_in`. With 2'b10, one advance happens per 60 rising edges. With 2'b11, nothing advances.
- R3: Addresses 0x20 to 0x26 hold, in order, seconds, minutes, hours, day of week, date, month and year, all in BCD. Any other address reads 0x00, and a write to it changes nothing.
- R4: Seconds and minutes go from 0x59 to 0x00. Each of these wraps advances the next register up.
- R5: In 24-hour mode (hours bit 6 = 0, bits 5:0 = BCD 00–23), the hour steps in BCD (0x09 to 0x10). From 0x23 it goes to 0x00 and starts a new day.
- R6: In 12-hour mode, bit 6 = 1, bit 5 = PM and bits 4:0 = BCD 01–12. The hour goes 12 to 01. At the 11 to 12 step the PM bit toggles, and a new day starts only when it goes from PM to AM.
- R7: On each new day, the day of week counts 1 to 7 and goes from 7 back to 1.
- R8: The date goes to 01 after the last day of the month. That is 30 for April, June, September and November, and 31 for the other months except February. February ends on 29 when the year is divisible by 4 (00 included), and on 28 otherwise.
- R9: When the date passes its last day, the month advances, going from 12 to 01. Passing December advances the year, which goes from 99 to 00.
- R10: A write to a mapped address loads on the next clock edge. On that edge it blocks any advance, and it clears the sub-second counts, so the next advance comes one full tick period later.
- R11: A change of `src_sel` clears the sub-second counts, so the next prescaler advance comes `PRESCALE_DIV` cycles after the change.
- R12: After reset the block reads 00:00:00 in 24-hour mode, day of week 1, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the prescaler reference |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Tick source: 00 prescaler, 01 line 50 Hz, 10 line 60 Hz, 11 hold |
| line_in | input | 1 | Mains-line pulse, synchronous to clk |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |

## Verification
The bench drives the chain across each rollover boundary: 23:59:59 in both hour modes, the last day of February in leap, non-leap and year-00 cases, 30- and 31-day months, and New Year of year 99. A design with a wrong month table or leap test would show 29 or 31 where 01 is due. A design with 12-hour errors would toggle PM at 12 to 01, or start a new day at noon. For the line sources, the bench counts pulses one short of the divider and then exactly at it, which exposes an off-by-one divider. It also times the first advance after a write or a source change to the cycle, so a design that keeps the stale sub-second count advances early.

// File: rtl/rtc_cal_pkg.sv
// Shared types and BCD helpers for the clock calendar chain.
// Assumes all counter values are packed BCD bytes.
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        SRC_PRESCALE = 2'b00,
        SRC_LINE50   = 2'b01,
        SRC_LINE60   = 2'b10,
        SRC_HOLD     = 2'b11
    } tick_src_e;

    localparam int NUM_FIELDS   = 7;
    localparam int F_SEC        = 0;
    localparam int F_MIN        = 1;
    localparam int F_HOUR       = 2;
    localparam int F_DOW        = 3;
    localparam int F_DATE       = 4;
    localparam int F_MONTH      = 5;
    localparam int F_YEAR       = 6;
    localparam int LINE50_COUNT = 50;
    localparam int LINE60_COUNT = 60;

    typedef struct packed {
        logic       carry;
        logic [7:0] value;
    } step_t;

    // Add one to a two-digit BCD byte.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Step a BCD counter, wrapping from its last value back to its first.
    function automatic logic [7:0] wrap_next(input logic [7:0] v,
                                             input logic [7:0] last,
                                             input logic [7:0] first);
        return (v == last) ? first : bcd_inc(v);
    endfunction

    // Last date of a month, given the BCD month and the low five bits of the BCD year.
    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [4:0] yr);
        logic leap;
        // BCD tens odd: units 2 or 6; tens even: units 0, 4 or 8
        leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                     : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
        if (mon == 8'h02)
            return leap ? 8'h29 : 8'h28;
        else if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11)
            return 8'h30;
        else
            return 8'h31;
    endfunction

    // Step the packed hours byte (bit 6 mode, bit 5 PM in 12 h); carry marks a new day.
    function automatic step_t hour_step(input logic [6:0] h);
        step_t      r;
        logic [7:0] nxt12;
        r.carry = 1'b0;
        nxt12   = bcd_inc({3'b000, h[4:0]});
        if (!h[6]) begin
            if (h[5:0] == 6'h23) begin
                r.value = 8'h00;
                r.carry = 1'b1;
            end else begin
                r.value = bcd_inc({2'b00, h[5:0]});
            end
        end else if (h[4:0] == 5'h11) begin
            r.value = {2'b01, ~h[5], 5'h12};
            r.carry = h[5];
        end else if (h[4:0] == 5'h12) begin
            r.value = {2'b01, h[5], 5'h01};
        end else begin
            r.value = {2'b01, h[5], nxt12[4:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
// One-second tick generator.
// Divides the block clock by PRESCALE_DIV, or counts rising edges of a
// mains-line pulse (50 or 60 per tick). The output is a one-cycle pulse.
// Assumes line_in is already synchronous to clk. clear_i, or any change of
// the source select, restarts the sub-second counts and blocks a tick.
module rtc_tick_gen
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       line_in,
    input  logic       clear_i,
    output logic       tick_o
);
    localparam int PRE_W  = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
    localparam int LINE_W = $clog2(LINE60_COUNT);
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(PRESCALE_DIV - 1);
    localparam logic [LINE_W-1:0] L50_LAST = LINE_W'(LINE50_COUNT - 1);
    localparam logic [LINE_W-1:0] L60_LAST = LINE_W'(LINE60_COUNT - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [LINE_W-1:0] line_cnt_q;
    logic              line_q;
    logic [1:0]        src_q;
    logic              line_rise;
    logic              restart;
    logic [LINE_W-1:0] line_last;
    logic              pre_hit;
    logic              line_hit;

    // Decode edges, the restart condition and the terminal counts
    always_comb begin
        line_rise = line_in & ~line_q;
        restart   = clear_i | (src_sel != src_q);
        line_last = (src_sel == SRC_LINE60) ? L60_LAST : L50_LAST;
        pre_hit   = (src_sel == SRC_PRESCALE) && (pre_q == PRE_LAST);
        line_hit  = (src_sel == SRC_LINE50 || src_sel == SRC_LINE60)
                    && line_rise && (line_cnt_q == line_last);
        tick_o    = ~restart & (pre_hit | line_hit);
    end

    // Sub-second counters for the prescaler and the line divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q      <= '0;
            line_cnt_q <= '0;
            line_q     <= 1'b0;
            src_q      <= SRC_PRESCALE;
        end else begin
            line_q <= line_in;
            src_q  <= src_sel;
            if (restart) begin
                pre_q      <= '0;
                line_cnt_q <= '0;
            end else if (src_sel == SRC_PRESCALE) begin
                pre_q <= pre_hit ? '0 : pre_q + 1'b1;
            end else if (src_sel != SRC_HOLD && line_rise) begin
                line_cnt_q <= line_hit ? '0 : line_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_time_chain.sv
// Cascade of seven BCD time and calendar counters.
// On a tick, seconds advance and each wrap passes a carry up the chain.
// A write loads one field and blocks every advance on that edge.
// Assumes software loads valid BCD values.
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tick_i,
    input  logic                             wr_i,
    input  logic [2:0]                       wr_sel_i,
    input  logic [7:0]                       wr_data_i,
    output logic [NUM_FIELDS-1:0][7:0]       regs_o
);
    logic [7:0]            regs_q   [NUM_FIELDS];
    logic [7:0]            next_val [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] inc_en;
    step_t                 hstep;
    logic                  c_min, c_hour, c_day, c_month, c_year;

    // Carry ripple: work out which fields advance and to what
    always_comb begin
        hstep   = hour_step(regs_q[F_HOUR][6:0]);
        c_min   = tick_i & (regs_q[F_SEC] == 8'h59);
        c_hour  = c_min & (regs_q[F_MIN] == 8'h59);
        c_day   = c_hour & hstep.carry;
        c_month = c_day & (regs_q[F_DATE] ==
                  month_last_day(regs_q[F_MONTH], regs_q[F_YEAR][4:0]));
        c_year  = c_month & (regs_q[F_MONTH] == 8'h12);

        inc_en            = {c_year, c_month, c_day, c_day, c_hour, c_min, tick_i};
        next_val[F_SEC]   = wrap_next(regs_q[F_SEC], 8'h59, 8'h00);
        next_val[F_MIN]   = wrap_next(regs_q[F_MIN], 8'h59, 8'h00);
        next_val[F_HOUR]  = hstep.value;
        next_val[F_DOW]   = wrap_next(regs_q[F_DOW], 8'h07, 8'h01);
        next_val[F_DATE]  = wrap_next(regs_q[F_DATE],
                            month_last_day(regs_q[F_MONTH], regs_q[F_YEAR][4:0]), 8'h01);
        next_val[F_MONTH] = wrap_next(regs_q[F_MONTH], 8'h12, 8'h01);
        next_val[F_YEAR]  = wrap_next(regs_q[F_YEAR], 8'h99, 8'h00);
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam logic [7:0] RST_VAL =
            (f == F_DOW || f == F_DATE || f == F_MONTH) ? 8'h01 : 8'h00;
        localparam logic [7:0] LOAD_MASK = (f == F_HOUR) ? 8'h7F : 8'hFF;

        // One field: reset, software load, or carry-driven advance
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[f] <= RST_VAL;
            else if (wr_i)
                regs_q[f] <= (wr_sel_i == 3'(f)) ? (wr_data_i & LOAD_MASK) : regs_q[f];
            else if (inc_en[f])
                regs_q[f] <= next_val[f];
        end

        assign regs_o[f] = regs_q[f];
    end

endmodule

// File: rtl/rtc_bcd_chain.sv
// Top of the BCD clock calendar: tick generator, counter chain and the
// register port. Seven fields sit at 0x20..0x26 and reads are combinational.
// Assumes ADDR_W >= 6 and synchronous register-port inputs.
module rtc_bcd_chain
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768,
    parameter int ADDR_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic              line_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W-4:0] BASE_HI = (ADDR_W-3)'(32 >> 3);

    logic                        addr_hit;
    logic [2:0]                  fidx;
    logic                        wr_hit;
    logic                        sec_tick;
    logic [NUM_FIELDS-1:0][7:0]  cal_regs;

    // Address decode: aligned window of seven fields
    always_comb begin
        fidx     = addr[2:0];
        addr_hit = (addr[ADDR_W-1:3] == BASE_HI) && (fidx != 3'd7);
        wr_hit   = wr_en & addr_hit;
        rd_data  = addr_hit ? cal_regs[fidx] : 8'h00;
    end

    rtc_tick_gen #(.PRESCALE_DIV(PRESCALE_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .line_in (line_in),
        .clear_i (wr_hit),
        .tick_o  (sec_tick)
    );

    rtc_time_chain u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (sec_tick),
        .wr_i      (wr_hit),
        .wr_sel_i  (fidx),
        .wr_data_i (wr_data),
        .regs_o    (cal_regs)
    );

endmodule

// File: rtl/rtc_bcd_chain_chk.sv
// Property checker for rtc_bcd_chain, attached with bind.
// Assumes it sees the internal tick, the decode and the field registers.
module rtc_bcd_chain_chk
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       addr_hit,
    input logic [2:0]                 fidx,
    input logic [7:0]                 wr_data,
    input logic                       tick,
    input logic [NUM_FIELDS-1:0][7:0] cal,
    input logic [7:0]                 rd_data
);
    localparam bit DIV_GT1 = (PRESCALE_DIV > 1);

    // R10: a seconds write lands on the next edge
    assert_write_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_hit && fidx == 3'd0) |=> cal[F_SEC] == $past(wr_data));

    // R10: the write edge restarts the sub-second count, so no tick follows at once
    assert_write_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (DIV_GT1 && wr_en && addr_hit) |=> !tick);

    // R1: without a tick or a write, the registers hold
    assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(wr_en && addr_hit)) |=> $stable(cal));

    // R4: seconds wrap to 00 and move the minutes
    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && addr_hit) && cal[F_SEC] == 8'h59)
        |=> (cal[F_SEC] == 8'h00 && cal[F_MIN] != $past(cal[F_MIN])));

    // R5: 24-hour midnight wraps the hours to 00 and moves the day of week
    assert_midnight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && addr_hit) && cal[F_SEC] == 8'h59 && cal[F_MIN] == 8'h59
         && cal[F_HOUR] == 8'h23)
        |=> (cal[F_HOUR] == 8'h00 && cal[F_DOW] != $past(cal[F_DOW])));

    // R6: the 11 to 12 step flips the PM bit in 12-hour mode
    assert_pm_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && addr_hit) && cal[F_SEC] == 8'h59 && cal[F_MIN] == 8'h59
         && cal[F_HOUR][6] && cal[F_HOUR][4:0] == 5'h11)
        |=> cal[F_HOUR][5] != $past(cal[F_HOUR][5]));

    // R3: unmapped addresses read zero
    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> rd_data == 8'h00);

endmodule

bind rtc_bcd_chain rtc_bcd_chain_chk #(.PRESCALE_DIV(PRESCALE_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr_hit (addr_hit),
    .fidx     (fidx),
    .wr_data  (wr_data),
    .tick     (sec_tick),
    .cal      (cal_regs),
    .rd_data  (rd_data)
);

// File: tb/rtc_bcd_chain_tb.sv
// Bench for rtc_bcd_chain: a behavioural calendar model compared on every
// clock, plus directed checks at the rollover boundaries.
module rtc_bcd_chain_tb;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       line_in = 1'b0;
    logic [5:0] addr = 6'h20;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit run_cmp = 1'b0;

    always #10 clk = ~clk;

    rtc_bcd_chain #(.PRESCALE_DIV(DIV), .ADDR_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .line_in(line_in),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    // ---------------- behavioural reference model ----------------
    int m_s, m_mi, m_h, m_dw, m_dt, m_mo, m_yr, m_pre, m_lc, m_src;
    bit m_12, m_pm, m_line;

    function automatic int dec(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mdays(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] m_read(input logic [5:0] a);
        logic [7:0] hb;
        hb = bcd(m_h);
        case (a)
            6'h20: return bcd(m_s);
            6'h21: return bcd(m_mi);
            6'h22: return m_12 ? {2'b01, m_pm, hb[4:0]} : hb;
            6'h23: return bcd(m_dw);
            6'h24: return bcd(m_dt);
            6'h25: return bcd(m_mo);
            6'h26: return bcd(m_yr);
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_write(input logic [5:0] a, input logic [7:0] d);
        case (a)
            6'h20: m_s  = dec(d);
            6'h21: m_mi = dec(d);
            6'h22: begin
                m_12 = d[6];
                if (d[6]) begin m_pm = d[5]; m_h = dec({3'b000, d[4:0]}); end
                else      begin m_pm = 1'b0; m_h = dec({2'b00, d[5:0]}); end
            end
            6'h23: m_dw = dec(d);
            6'h24: m_dt = dec(d);
            6'h25: m_mo = dec(d);
            6'h26: m_yr = dec(d);
            default: ;
        endcase
    endtask

    task automatic m_tick();
        bit nd;
        nd = 1'b0;
        if (m_s == 59) begin
            m_s = 0;
            if (m_mi == 59) begin
                m_mi = 0;
                if (!m_12) begin
                    if (m_h == 23) begin m_h = 0; nd = 1'b1; end
                    else m_h++;
                end else begin
                    if (m_h == 11) begin m_h = 12; nd = m_pm; m_pm = !m_pm; end
                    else if (m_h == 12) m_h = 1;
                    else m_h++;
                end
            end else m_mi++;
        end else m_s++;
        if (nd) begin
            m_dw = (m_dw == 7) ? 1 : m_dw + 1;
            if (m_dt == mdays(m_mo, m_yr)) begin
                m_dt = 1;
                if (m_mo == 12) begin m_mo = 1; m_yr = (m_yr == 99) ? 0 : m_yr + 1; end
                else m_mo++;
            end else m_dt++;
        end
    endtask

    // Model update at each active edge, from the inputs driven away from it
    always @(posedge clk) begin : model_b
        bit hit, clr, tk, edg;
        if (!rst_n) begin
            m_s = 0; m_mi = 0; m_h = 0; m_12 = 0; m_pm = 0;
            m_dw = 1; m_dt = 1; m_mo = 1; m_yr = 0;
            m_pre = 0; m_lc = 0; m_src = 0; m_line = 0;
        end else begin
            hit = wr_en && addr >= 6'h20 && addr <= 6'h26;
            clr = hit || (int'(src_sel) != m_src);
            edg = line_in && !m_line;
            tk  = 1'b0;
            if (clr) begin
                m_pre = 0; m_lc = 0;
            end else if (src_sel == 2'b00) begin
                if (m_pre == DIV - 1) begin tk = 1'b1; m_pre = 0; end else m_pre++;
            end else if (src_sel != 2'b11 && edg) begin
                if (m_lc == ((src_sel == 2'b01) ? 49 : 59)) begin tk = 1'b1; m_lc = 0; end
                else m_lc++;
            end
            m_line = line_in;
            m_src  = int'(src_sel);
            if (hit) m_write(addr, wr_data);
            else if (tk) m_tick();
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison of the addressed register against the model (R3 map, all rules)
    always @(negedge clk) begin
        if (run_cmp) begin
            #6;
            check("R3 model", rd_data, m_read(addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #5;
        check(tag, rd_data, exp);
    endtask

    task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] yr);
        wr(6'h21, mi); wr(6'h22, h); wr(6'h23, dw); wr(6'h24, dt);
        wr(6'h25, mo); wr(6'h26, yr); wr(6'h20, s);
    endtask

    task automatic wait_secs(input int n);
        repeat (n * DIV) @(posedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) line_in = 1'b1;
            @(negedge clk) line_in = 1'b0;
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        run_cmp = 1'b1;

        // R12: reset values
        rd(6'h20, "R12 sec", 8'h00);  rd(6'h21, "R12 min", 8'h00);
        rd(6'h22, "R12 hour", 8'h00); rd(6'h23, "R12 dow", 8'h01);
        rd(6'h24, "R12 date", 8'h01); rd(6'h25, "R12 month", 8'h01);
        rd(6'h26, "R12 year", 8'h00);

        // R1, R4: prescaler ticks over 70 seconds
        wr(6'h20, 8'h00);
        wait_secs(70);
        rd(6'h20, "R1 sec after 70 s", 8'h10);
        rd(6'h21, "R4 minute carry", 8'h01);

        // R5, R7, R8: midnight into leap day
        set_all(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24);
        wait_secs(2);
        rd(6'h20, "R4 sec wrap", 8'h00); rd(6'h22, "R5 hour wrap", 8'h00);
        rd(6'h23, "R7 dow wrap", 8'h01); rd(6'h24, "R8 leap 29th", 8'h29);
        rd(6'h25, "R8 still Feb", 8'h02);

        set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        wait_secs(1);
        rd(6'h24, "R8 leap end", 8'h01); rd(6'h25, "R9 to March", 8'h03);

        set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        wait_secs(1);
        rd(6'h24, "R8 non-leap end", 8'h01); rd(6'h25, "R8 non-leap month", 8'h03);

        set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
        wait_secs(1);
        rd(6'h24, "R8 year 00 leap", 8'h29);

        set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h24);
        wait_secs(1);
        rd(6'h24, "R8 30-day end", 8'h01); rd(6'h25, "R8 to May", 8'h05);

        set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h05, 8'h24);
        wait_secs(1);
        rd(6'h24, "R8 31-day month", 8'h31);

        // R9: New Year of year 99
        set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        wait_secs(1);
        rd(6'h24, "R9 date", 8'h01); rd(6'h25, "R9 month wrap", 8'h01);
        rd(6'h26, "R9 year wrap", 8'h00);

        // R5: BCD hour step 09 -> 10
        set_all(8'h59, 8'h59, 8'h09, 8'h01, 8'h10, 8'h06, 8'h24);
        wait_secs(1);
        rd(6'h22, "R5 hour BCD step", 8'h10);

        // R6: 12-hour mode
        set_all(8'h59, 8'h59, 8'h51, 8'h01, 8'h10, 8'h06, 8'h24);
        wait_secs(1);
        rd(6'h22, "R6 11AM to 12PM", 8'h72); rd(6'h24, "R6 no day at noon", 8'h10);
        set_all(8'h59, 8'h59, 8'h72, 8'h01, 8'h10, 8'h06, 8'h24);
        wait_secs(1);
        rd(6'h22, "R6 12PM to 1PM", 8'h61);
        set_all(8'h59, 8'h59, 8'h71, 8'h01, 8'h10, 8'h06, 8'h24);
        wait_secs(1);
        rd(6'h22, "R6 11PM to 12AM", 8'h52); rd(6'h24, "R6 new day", 8'h11);
        rd(6'h23, "R7 dow step", 8'h02);

        // R10: first advance a full tick period after a write
        wr(6'h20, 8'h30);
        repeat (DIV - 1) @(posedge clk);
        rd(6'h20, "R10 held before period", 8'h30);
        rd(6'h20, "R10 advance at period", 8'h31);

        // R11: source change restarts the sub-second count
        wr(6'h20, 8'h10);
        repeat (5) @(posedge clk);
        @(negedge clk) src_sel = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk) src_sel = 2'b00;
        @(posedge clk);
        repeat (DIV - 1) @(posedge clk);
        rd(6'h20, "R11 held after switch", 8'h10);
        rd(6'h20, "R11 advance after switch", 8'h11);

        // R2: line sources and hold
        wr(6'h20, 8'h00);
        @(negedge clk) src_sel = 2'b01;
        pulses(49);
        rd(6'h20, "R2 49 pulses at 50", 8'h00);
        pulses(1);
        rd(6'h20, "R2 50 pulses at 50", 8'h01);
        @(negedge clk) src_sel = 2'b10;
        pulses(59);
        rd(6'h20, "R2 59 pulses at 60", 8'h01);
        pulses(1);
        rd(6'h20, "R2 60 pulses at 60", 8'h02);
        @(negedge clk) src_sel = 2'b11;
        pulses(60);
        repeat (100) @(posedge clk);
        rd(6'h20, "R2 hold source", 8'h02);

        // R3: unmapped addresses
        wr(6'h20, 8'h33);
        wr(6'h27, 8'h55); wr(6'h07, 8'h44); wr(6'h3F, 8'h66);
        rd(6'h27, "R3 read 0x27", 8'h00);
        rd(6'h07, "R3 read 0x07", 8'h00);
        rd(6'h3F, "R3 read 0x3F", 8'h00);
        rd(6'h20, "R3 writes ignored", 8'h33);

        @(negedge clk) src_sel = 2'b00;
        repeat (3 * DIV) @(posedge clk);
        run_cmp = 1'b0;
        #30;
        summary();
        $finish;
    end

endmodule